// File: doc/BRIEF.md
# Trap Cause Priority Selector

This block takes every exception condition that a capability-extended RISC-V hart can raise for one instruction in one cycle and reduces them to a single winning trap cause. The conditions come from two sides. On the fetch side there is the instruction breakpoint, the program-counter-capability check, the translation faults and the physical access fault. On the data side there is the data breakpoint, misalignment, the translation faults, the capability page-table-entry fault and the physical access fault. The block orders them in a fixed priority and drives a valid flag, the cause code, and a flag for the case where an ordinary data page fault and a capability PTE fault were detected together.

The capability PTE fault has two priority levels. A store or atomic that writes a set tag, or a load that does not check the loaded tag, takes the fault at the translation level. A load that checks the loaded tag takes the fault below every other condition, with the load page fault code. The code for the capability fault is a parameter. A parameter selects whether misalignment is ranked before translation or after the physical access check. A second parameter adds one register stage with a synchronous reset.

The interface carries no data stream, so there is no valid/ready handshake. Every request is a plain level that is sampled each cycle, and the result is produced either in the same cycle or one cycle later.

Top module: `trap_cause_select`

## Requirements
- R1: `fetch_bkpt` wins over every other request and gives cause 3.
- R2: `pcc_fault` gives cause `CAP_CAUSE` (default 28). It loses only to `fetch_bkpt` and beats every other request.
- R3: The fetch-side order is `fetch_page_fault` (cause 12), then `fetch_xlat_access` (cause 1), then `fetch_phys_access` (cause 1). Every fetch-side request outranks every data-side request.
- R4: `data_bkpt` gives cause 3. It outranks all data-side faults, including misalignment.
- R5: `data_page_fault` gives cause 13 when `data_is_store`=0 and 15 when `data_is_store`=1. It outranks `data_xlat_access`, which gives cause 5 for a load and 7 for a store.
- R6: `cap_pte_fault` with `data_is_store`=1, or with `load_tag_checked`=0, gives cause 13 or 15 at the same rank as `data_page_fault`. It therefore beats `data_phys_access`.
- R7: `data_phys_access` gives cause 5 for a load and 7 for a store. With `MISALIGN_EARLY`=0 it outranks `data_misalign`, which gives cause 4 for a load and 6 for a store.
- R8: `cap_pte_fault` on a load with `load_tag_checked`=1 has the lowest rank and gives cause 13. It loses to misalignment and to the data access faults.
- R9: `trap_dual_pf` is 1 exactly when the data page-fault rank wins while `data_page_fault` and `cap_pte_fault` are both asserted. In that case the cause is 13 or 15.
- R10: With no request asserted, `trap_valid`=0, `trap_cause`=0 and `trap_dual_pf`=0.
- R11: With `REG_OUT`=1 (the default), the outputs reflect the inputs of the previous clock edge. A cycle with `rst`=1 leaves all three outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous reset, active high |
| fetch_bkpt | input | 1 | Instruction address breakpoint hit |
| pcc_fault | input | 1 | Program-counter-capability check failed |
| fetch_page_fault | input | 1 | Page fault during fetch translation |
| fetch_xlat_access | input | 1 | Access fault during fetch translation |
| fetch_phys_access | input | 1 | Access fault on the physical fetch address |
| data_bkpt | input | 1 | Load/store/AMO address breakpoint hit |
| data_is_store | input | 1 | 1: store or AMO, 0: load |
| data_misalign | input | 1 | Data address misaligned |
| data_page_fault | input | 1 | Ordinary page fault during data translation |
| data_xlat_access | input | 1 | Access fault during data translation |
| cap_pte_fault | input | 1 | Capability PTE fault detected |
| load_tag_checked | input | 1 | The capability load checks the loaded tag |
| data_phys_access | input | 1 | Access fault on the physical data address |
| trap_valid | output | 1 | Some request won |
| trap_cause | output | CAUSE_W | Winning cause code, 0 when idle |
| trap_dual_pf | output | 1 | Page fault and capability PTE fault seen together |

## Verification
A wrong rank in the priority chain appears as the wrong cause code in the first output cycle after the offending pair of requests, one clock after they are applied. A wrong split of the capability PTE fault between its two levels shows only when the fault is paired with an access fault or with misalignment. For that reason those pairs are driven for each combination of access kind and tag-check flag. A bad output register or reset shows as a stale valid flag in the cycle after reset or after requests are removed.

// File: rtl/trap_sel_pkg.sv
package trap_sel_pkg;

  typedef struct packed {
    logic fetch_bkpt;
    logic pcc_fault;
    logic fetch_pf;
    logic fetch_xaf;
    logic fetch_paf;
    logic data_bkpt;
    logic is_store;
    logic misalign;
    logic data_pf;
    logic data_xaf;
    logic cap_pte;
    logic tag_checked;
    logic data_paf;
  } trap_req_t;

  // Rank order: lower index wins.
  localparam int SL_FBKPT     = 0;
  localparam int SL_PCC       = 1;
  localparam int SL_FPF       = 2;
  localparam int SL_FXAF      = 3;
  localparam int SL_FPAF      = 4;
  localparam int SL_DBKPT     = 5;
  localparam int SL_MIS_EARLY = 6;
  localparam int SL_DPF       = 7;
  localparam int SL_DXAF      = 8;
  localparam int SL_DPAF      = 9;
  localparam int SL_MIS_LATE  = 10;
  localparam int SL_CPTE_LATE = 11;
  localparam int NSLOT        = 12;

  localparam int C_FETCH_AF  = 1;
  localparam int C_BKPT      = 3;
  localparam int C_LD_MIS    = 4;
  localparam int C_LD_AF     = 5;
  localparam int C_ST_MIS    = 6;
  localparam int C_ST_AF     = 7;
  localparam int C_FETCH_PF  = 12;
  localparam int C_LD_PF     = 13;
  localparam int C_ST_PF     = 15;

endpackage

// File: rtl/trap_req_decode.sv
module trap_req_decode
  import trap_sel_pkg::*;
#(
  parameter int CAUSE_W        = 6,
  parameter int CAP_CAUSE      = 28,
  parameter bit MISALIGN_EARLY = 1'b0
) (
  input  trap_req_t                       req,
  output logic [NSLOT-1:0]                slot_req,
  output logic [NSLOT-1:0][CAUSE_W-1:0]   slot_cause
);

  logic cap_early, cap_late;
  logic mis_early, mis_late;
  logic [CAUSE_W-1:0] pf_code, af_code, mis_code;

  assign cap_early = req.cap_pte & (req.is_store | ~req.tag_checked);
  assign cap_late  = req.cap_pte & ~req.is_store & req.tag_checked;

  generate
    if (MISALIGN_EARLY) begin : g_mis_early
      assign mis_early = req.misalign;
      assign mis_late  = 1'b0;
    end else begin : g_mis_late
      assign mis_early = 1'b0;
      assign mis_late  = req.misalign;
    end
  endgenerate

  assign pf_code  = req.is_store ? CAUSE_W'(C_ST_PF)  : CAUSE_W'(C_LD_PF);
  assign af_code  = req.is_store ? CAUSE_W'(C_ST_AF)  : CAUSE_W'(C_LD_AF);
  assign mis_code = req.is_store ? CAUSE_W'(C_ST_MIS) : CAUSE_W'(C_LD_MIS);

  always_comb begin
    slot_req = '0;
    slot_req[SL_FBKPT]     = req.fetch_bkpt;
    slot_req[SL_PCC]       = req.pcc_fault;
    slot_req[SL_FPF]       = req.fetch_pf;
    slot_req[SL_FXAF]      = req.fetch_xaf;
    slot_req[SL_FPAF]      = req.fetch_paf;
    slot_req[SL_DBKPT]     = req.data_bkpt;
    slot_req[SL_MIS_EARLY] = mis_early;
    slot_req[SL_DPF]       = req.data_pf | cap_early;
    slot_req[SL_DXAF]      = req.data_xaf;
    slot_req[SL_DPAF]      = req.data_paf;
    slot_req[SL_MIS_LATE]  = mis_late;
    slot_req[SL_CPTE_LATE] = cap_late;

    slot_cause = '0;
    slot_cause[SL_FBKPT]     = CAUSE_W'(C_BKPT);
    slot_cause[SL_PCC]       = CAUSE_W'(CAP_CAUSE);
    slot_cause[SL_FPF]       = CAUSE_W'(C_FETCH_PF);
    slot_cause[SL_FXAF]      = CAUSE_W'(C_FETCH_AF);
    slot_cause[SL_FPAF]      = CAUSE_W'(C_FETCH_AF);
    slot_cause[SL_DBKPT]     = CAUSE_W'(C_BKPT);
    slot_cause[SL_MIS_EARLY] = mis_code;
    slot_cause[SL_DPF]       = pf_code;
    slot_cause[SL_DXAF]      = af_code;
    slot_cause[SL_DPAF]      = af_code;
    slot_cause[SL_MIS_LATE]  = mis_code;
    slot_cause[SL_CPTE_LATE] = CAUSE_W'(C_LD_PF);
  end

endmodule

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter int N = 12,
  parameter int W = 6
) (
  input  logic [N-1:0]        req,
  input  logic [N-1:0][W-1:0] cause,
  output logic                any,
  output logic [N-1:0]        win,
  output logic [W-1:0]        sel_cause
);

  logic [N:0] taken;

  assign taken[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rank
      assign win[gi]     = req[gi] & ~taken[gi];
      assign taken[gi+1] = taken[gi] | req[gi];
    end
  endgenerate

  assign any = taken[N];

  always_comb begin
    sel_cause = '0;
    for (int i = 0; i < N; i++) begin
      sel_cause |= {W{win[i]}} & cause[i];
    end
  end

endmodule

// File: rtl/trap_out_stage.sv
module trap_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/trap_cause_select.sv
module trap_cause_select
  import trap_sel_pkg::*;
#(
  parameter int CAUSE_W        = 6,
  parameter int CAP_CAUSE      = 28,
  parameter bit MISALIGN_EARLY = 1'b0,
  parameter bit REG_OUT        = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_bkpt,
  input  logic               pcc_fault,
  input  logic               fetch_page_fault,
  input  logic               fetch_xlat_access,
  input  logic               fetch_phys_access,
  input  logic               data_bkpt,
  input  logic               data_is_store,
  input  logic               data_misalign,
  input  logic               data_page_fault,
  input  logic               data_xlat_access,
  input  logic               cap_pte_fault,
  input  logic               load_tag_checked,
  input  logic               data_phys_access,
  output logic               trap_valid,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               trap_dual_pf
);

  localparam int OW = CAUSE_W + 2;

  trap_req_t                     req;
  logic [NSLOT-1:0]              slot_req;
  logic [NSLOT-1:0][CAUSE_W-1:0] slot_cause;
  logic [NSLOT-1:0]              win;
  logic                          pick_valid;
  logic [CAUSE_W-1:0]            pick_cause;
  logic                          pick_dual;
  logic [OW-1:0]                 stage_d, stage_q;

  assign req = '{
    fetch_bkpt:  fetch_bkpt,
    pcc_fault:   pcc_fault,
    fetch_pf:    fetch_page_fault,
    fetch_xaf:   fetch_xlat_access,
    fetch_paf:   fetch_phys_access,
    data_bkpt:   data_bkpt,
    is_store:    data_is_store,
    misalign:    data_misalign,
    data_pf:     data_page_fault,
    data_xaf:    data_xlat_access,
    cap_pte:     cap_pte_fault,
    tag_checked: load_tag_checked,
    data_paf:    data_phys_access
  };

  trap_req_decode #(
    .CAUSE_W       (CAUSE_W),
    .CAP_CAUSE     (CAP_CAUSE),
    .MISALIGN_EARLY(MISALIGN_EARLY)
  ) u_decode (
    .req       (req),
    .slot_req  (slot_req),
    .slot_cause(slot_cause)
  );

  trap_prio_pick #(
    .N(NSLOT),
    .W(CAUSE_W)
  ) u_pick (
    .req      (slot_req),
    .cause    (slot_cause),
    .any      (pick_valid),
    .win      (win),
    .sel_cause(pick_cause)
  );

  // Both faults are recorded when the page-fault rank wins with both present.
  assign pick_dual = win[SL_DPF] & data_page_fault & cap_pte_fault;
  assign stage_d   = {pick_valid, pick_dual, pick_cause};

  trap_out_stage #(
    .W      (OW),
    .REG_OUT(REG_OUT)
  ) u_stage (
    .clk(clk),
    .rst(rst),
    .d  (stage_d),
    .q  (stage_q)
  );

  assign trap_valid   = stage_q[OW-1];
  assign trap_dual_pf = stage_q[OW-2];
  assign trap_cause   = stage_q[CAUSE_W-1:0];

endmodule

// File: rtl/trap_cause_select_chk.sv
module trap_cause_select_chk #(
  parameter int CAUSE_W   = 6,
  parameter int CAP_CAUSE = 28,
  parameter bit REG_OUT   = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_bkpt,
  input logic               pcc_fault,
  input logic               fetch_page_fault,
  input logic               fetch_xlat_access,
  input logic               fetch_phys_access,
  input logic               data_bkpt,
  input logic               data_misalign,
  input logic               data_page_fault,
  input logic               data_xlat_access,
  input logic               cap_pte_fault,
  input logic               data_phys_access,
  input logic               trap_valid,
  input logic [CAUSE_W-1:0] trap_cause,
  input logic               trap_dual_pf
);

  logic any_req;
  assign any_req = fetch_bkpt | pcc_fault | fetch_page_fault | fetch_xlat_access |
                   fetch_phys_access | data_bkpt | data_misalign | data_page_fault |
                   data_xlat_access | cap_pte_fault | data_phys_access;

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |-> (trap_cause == '0) && !trap_dual_pf);

  p_dual_pf_cause_r9: assert property (@(posedge clk) disable iff (rst)
    trap_dual_pf |-> trap_valid &&
      (trap_cause == CAUSE_W'(13) || trap_cause == CAUSE_W'(15)));

  generate
    if (REG_OUT) begin : g_seq
      p_fetch_bkpt_r1: assert property (@(posedge clk) disable iff (rst)
        fetch_bkpt |=> trap_valid && trap_cause == CAUSE_W'(3));
      p_pcc_rank_r2: assert property (@(posedge clk) disable iff (rst)
        (pcc_fault && !fetch_bkpt) |=> trap_cause == CAUSE_W'(CAP_CAUSE));
      p_valid_up_r11: assert property (@(posedge clk) disable iff (rst)
        any_req |=> trap_valid);
      p_valid_down_r11: assert property (@(posedge clk) disable iff (rst)
        !any_req |=> !trap_valid);
    end else begin : g_comb
      p_fetch_bkpt_r1: assert property (@(posedge clk) disable iff (rst)
        fetch_bkpt |-> trap_valid && trap_cause == CAUSE_W'(3));
      p_pcc_rank_r2: assert property (@(posedge clk) disable iff (rst)
        (pcc_fault && !fetch_bkpt) |-> trap_cause == CAUSE_W'(CAP_CAUSE));
      p_valid_up_r11: assert property (@(posedge clk) disable iff (rst)
        any_req |-> trap_valid);
      p_valid_down_r11: assert property (@(posedge clk) disable iff (rst)
        !any_req |-> !trap_valid);
    end
  endgenerate

endmodule

bind trap_cause_select trap_cause_select_chk #(
  .CAUSE_W  (CAUSE_W),
  .CAP_CAUSE(CAP_CAUSE),
  .REG_OUT  (REG_OUT)
) i_chk (
  .clk              (clk),
  .rst              (rst),
  .fetch_bkpt       (fetch_bkpt),
  .pcc_fault        (pcc_fault),
  .fetch_page_fault (fetch_page_fault),
  .fetch_xlat_access(fetch_xlat_access),
  .fetch_phys_access(fetch_phys_access),
  .data_bkpt        (data_bkpt),
  .data_misalign    (data_misalign),
  .data_page_fault  (data_page_fault),
  .data_xlat_access (data_xlat_access),
  .cap_pte_fault    (cap_pte_fault),
  .data_phys_access (data_phys_access),
  .trap_valid       (trap_valid),
  .trap_cause       (trap_cause),
  .trap_dual_pf     (trap_dual_pf)
);

// File: tb/test_trap_cause_select.sv
module test_trap_cause_select;

  localparam int CW  = 6;
  localparam int CAP = 28;

  // Stimulus bit positions.
  localparam int FBK = 0, PCC = 1, FPF = 2, FXA = 3, FPA = 4, DBK = 5, STO = 6;
  localparam int MIS = 7, DPF = 8, DXA = 9, CPT = 10, TCK = 11, DPA = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [12:0]   stim = '0;
  logic          trap_valid;
  logic [CW-1:0] trap_cause;
  logic          trap_dual_pf;
  int            n_checks = 0;
  int            n_fails  = 0;
  bit            done     = 1'b0;

  always #5 clk = ~clk;

  trap_cause_select #(.CAUSE_W(CW), .CAP_CAUSE(CAP)) i_trap_cause_select (
    .clk              (clk),
    .rst              (rst),
    .fetch_bkpt       (stim[FBK]),
    .pcc_fault        (stim[PCC]),
    .fetch_page_fault (stim[FPF]),
    .fetch_xlat_access(stim[FXA]),
    .fetch_phys_access(stim[FPA]),
    .data_bkpt        (stim[DBK]),
    .data_is_store    (stim[STO]),
    .data_misalign    (stim[MIS]),
    .data_page_fault  (stim[DPF]),
    .data_xlat_access (stim[DXA]),
    .cap_pte_fault    (stim[CPT]),
    .load_tag_checked (stim[TCK]),
    .data_phys_access (stim[DPA]),
    .trap_valid       (trap_valid),
    .trap_cause       (trap_cause),
    .trap_dual_pf     (trap_dual_pf)
  );

  function automatic logic [12:0] bits(input int a, input int b = -1, input int c = -1,
                                       input int d = -1);
    logic [12:0] v = '0;
    if (a >= 0) v[a] = 1'b1;
    if (b >= 0) v[b] = 1'b1;
    if (c >= 0) v[c] = 1'b1;
    if (d >= 0) v[d] = 1'b1;
    return v;
  endfunction

  task automatic expect_out(input string req, input logic v, input int c, input logic d);
    n_checks++;
    if (trap_valid !== v || trap_cause !== CW'(c) || trap_dual_pf !== d) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b cause=%0d dual=%0b, expected valid=%0b cause=%0d dual=%0b",
               req, trap_valid, trap_cause, trap_dual_pf, v, c, d);
    end
  endtask

  // Drive at a falling edge, register at the rising edge, sample at the next falling edge.
  task automatic apply(input logic [12:0] s, input string req, input logic v, input int c,
                       input logic d);
    @(negedge clk);
    stim = s;
    @(negedge clk);
    expect_out(req, v, c, d);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    expect_out("R11 reset", 1'b0, 0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R10 idle after reset", 1'b0, 0, 1'b0);
  endtask

  task automatic t_fetch_side;
    apply('1 & ~bits(TCK), "R1 all requests", 1'b1, 3, 1'b0);
    apply(bits(FBK), "R1 breakpoint alone", 1'b1, 3, 1'b0);
    apply(bits(PCC, FPF, FPA, DBK), "R2 pcc over fetch faults", 1'b1, CAP, 1'b0);
    apply(bits(FPF, FXA, FPA), "R3 fetch page fault", 1'b1, 12, 1'b0);
    apply(bits(FXA, FPA, DPF), "R3 fetch xlat access", 1'b1, 1, 1'b0);
    apply(bits(FPA, DBK), "R3 fetch phys over data", 1'b1, 1, 1'b0);
  endtask

  task automatic t_data_side;
    apply(bits(DBK, DPF, MIS, STO), "R4 data breakpoint", 1'b1, 3, 1'b0);
    apply(bits(DPF, DXA), "R5 load page fault", 1'b1, 13, 1'b0);
    apply(bits(DPF, DXA, STO), "R5 store page fault", 1'b1, 15, 1'b0);
    apply(bits(DXA, DPA, MIS), "R5 load xlat access", 1'b1, 5, 1'b0);
    apply(bits(DXA, STO), "R5 store xlat access", 1'b1, 7, 1'b0);
    apply(bits(DPA, MIS, STO), "R7 store phys over misalign", 1'b1, 7, 1'b0);
    apply(bits(DPA, MIS), "R7 load phys over misalign", 1'b1, 5, 1'b0);
    apply(bits(MIS), "R7 load misalign", 1'b1, 4, 1'b0);
    apply(bits(MIS, STO), "R7 store misalign", 1'b1, 6, 1'b0);
  endtask

  task automatic t_cap_pte;
    apply(bits(CPT, DPA, STO), "R6 store cap pte early", 1'b1, 15, 1'b0);
    apply(bits(CPT, DPA), "R6 unchecked load cap pte early", 1'b1, 13, 1'b0);
    apply(bits(CPT, DPA, TCK, STO), "R6 store ignores tag check", 1'b1, 15, 1'b0);
    apply(bits(CPT, TCK, DPA), "R8 checked load loses to phys", 1'b1, 5, 1'b0);
    apply(bits(CPT, TCK, MIS), "R8 checked load loses to misalign", 1'b1, 4, 1'b0);
    apply(bits(CPT, TCK, DXA), "R8 checked load loses to xlat", 1'b1, 5, 1'b0);
    apply(bits(CPT, TCK), "R8 checked load alone", 1'b1, 13, 1'b0);
  endtask

  task automatic t_dual;
    apply(bits(DPF, CPT, STO), "R9 store both faults", 1'b1, 15, 1'b1);
    apply(bits(DPF, CPT, TCK), "R9 checked load both faults", 1'b1, 13, 1'b1);
    apply(bits(DPF), "R9 page fault alone", 1'b1, 13, 1'b0);
    apply(bits(DBK, DPF, CPT), "R9 higher rank wins", 1'b1, 3, 1'b0);
  endtask

  task automatic t_idle_and_reset;
    apply(bits(STO, TCK), "R10 qualifiers only", 1'b0, 0, 1'b0);
    apply('0, "R10 no request", 1'b0, 0, 1'b0);
    @(negedge clk);
    stim = bits(FBK);
    rst  = 1'b1;
    @(negedge clk);
    expect_out("R11 reset blocks request", 1'b0, 0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    expect_out("R11 one-cycle latency", 1'b1, 3, 1'b0);
    stim = '0;
  endtask

  initial begin
    t_reset_state();
    t_fetch_side();
    t_data_side();
    t_cap_pte();
    t_dual();
    t_idle_and_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule